// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This unit keeps the exception and trap-control state that sits beside a floating-point datapath. After every floating-point operation the datapath presents five raw exception indications. The unit records them as the current-exception field, which always describes only the latest operation. It then checks each raised class against a per-class trap-enable mask. If no raised class is enabled, the flags are ORed into a sticky accrued field. If any raised class is enabled, the unit issues a one-cycle trap request and records an IEEE-exception trap type, and the accrued field is left alone.

Compare results from the datapath are stored in a two-bit condition-code field. The rounding selection is held in the register and driven straight to the datapath. The occupancy of the deferred-trap queue is shown as a read-only bit.

Supervisor software reads the whole register in one word and can write it in one word. A write takes priority over any hardware update in the same cycle.

Top module: `fpx_status_unit`

## Requirements
- R1: A synchronous active-high reset clears every stored field and trap_req. After reset, csr_rd_data reads zero apart from bit 22, which follows queue_busy.
- R2: When csr_wr_en is high, csr_wr_data[21:0] is stored and read back on csr_rd_data[21:0] from the next cycle. The word layout is: rounding [1:0], trap-enable mask [6:2], current exceptions [11:7], accrued exceptions [16:12], condition code [18:17], trap type [21:19]. Bits [31:23] always read 0.
- R3: Each exception vector uses this bit order: bit 4 invalid operation, bit 3 overflow, bit 2 underflow, bit 1 division by zero, bit 0 inexact. The cycle after op_valid, the current-exception field equals op_flags, so any class that was not raised is cleared.
- R4: When op_valid is high and no raised flag has its mask bit set, the accrued field becomes its old value ORed with op_flags.
- R5: When op_valid is high and any raised flag has its mask bit set, the next cycle shows trap_req high and trap type 1 (IEEE exception), and the accrued field is unchanged. The trap type holds until software writes it.
- R6: trap_req is high only in the cycle after an operation covered by R5.
- R7: When cmp_valid is high, the condition code takes cmp_cc (0 equal, 1 less, 2 greater, 3 unordered). A compare changes no exception field.
- R8: round_mode always equals the stored rounding field (0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity).
- R9: csr_rd_data bit 22 equals queue_busy in the same cycle (1 means the queue holds entries). Writes to bit 22 have no effect.
- R10: An operation or compare in the same cycle as a software write is dropped. The written value is what reads back, and trap_req stays low.
- R11: In a cycle with neither op_valid nor a write, the current and accrued fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | Software write strobe |
| csr_wr_data | input | 32 | Software write word |
| csr_rd_data | output | 32 | Register read word |
| op_valid | input | 1 | A floating-point operation completed |
| op_flags | input | 5 | Raw exception flags of that operation |
| cmp_valid | input | 1 | A compare result is presented |
| cmp_cc | input | 2 | Compare outcome code |
| queue_busy | input | 1 | Deferred-trap queue holds entries |
| round_mode | output | 2 | Rounding direction to the datapath |
| trap_req | output | 1 | One-cycle floating-point trap request |

## Verification
The assertions check the one-cycle relations on every cycle, using only values visible at the ports. These are: the current field following the latest flags, the masked accumulation, the trap outcome with an unchanged accrued field, the absence of a spurious trap request, compare capture, write readback and field hold in idle cycles. The bench's scenarios are what show the longer histories. One is an accrued value built up over many masked operations and then survived by a trap. Another is a trap type that persists across idle cycles until it is rewritten. The bench also covers collisions between a write and an operation, and the rounding output after rewrites.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int EXC_N   = 5;
    localparam int CSR_W   = 32;
    localparam int TT_W    = 3;
    localparam int QNE_BIT = 22;

    localparam int EXC_NX = 0;
    localparam int EXC_DZ = 1;
    localparam int EXC_UF = 2;
    localparam int EXC_OF = 3;
    localparam int EXC_NV = 4;

    localparam logic [TT_W-1:0] TT_NONE = 3'd0;
    localparam logic [TT_W-1:0] TT_IEEE = 3'd1;

    typedef logic [EXC_N-1:0] exc_vec_t;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_POS     = 2'd2,
        RM_NEG     = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        CC_EQ = 2'd0,
        CC_LT = 2'd1,
        CC_GT = 2'd2,
        CC_UN = 2'd3
    } fcc_e;

    // Field order, MSB first, matches the software word bits [21:0].
    typedef struct packed {
        logic [TT_W-1:0] tt;
        fcc_e            fcc;
        exc_vec_t        aexc;
        exc_vec_t        cexc;
        exc_vec_t        tem;
        rmode_e          rm;
    } fpx_state_t;

    localparam int STATE_W = $bits(fpx_state_t);
    localparam int PAD_W   = CSR_W - STATE_W - 1;

    // Field offsets inside the software word.
    localparam int RM_LSB   = 0;
    localparam int TEM_LSB  = 2;
    localparam int CEXC_LSB = TEM_LSB + EXC_N;
    localparam int AEXC_LSB = CEXC_LSB + EXC_N;
    localparam int FCC_LSB  = AEXC_LSB + EXC_N;
    localparam int TT_LSB   = FCC_LSB + 2;

    function automatic logic [CSR_W-1:0] fpx_pack(fpx_state_t s, logic qne);
        return {{PAD_W{1'b0}}, qne, s};
    endfunction

    function automatic fpx_state_t fpx_unpack(logic [CSR_W-1:0] w);
        return fpx_state_t'(w[STATE_W-1:0]);
    endfunction

endpackage

// File: rtl/fpx_exc_eval.sv
module fpx_exc_eval #(
    parameter int N = fpx_pkg::EXC_N
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] aexc_cur,
    output logic         trap_hit,
    output logic [N-1:0] aexc_next
);
    logic [N-1:0] enabled_hit;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cls
            assign enabled_hit[g] = flags[g] & mask[g];
        end
    endgenerate

    always_comb begin
        trap_hit  = |enabled_hit;
        aexc_next = trap_hit ? aexc_cur : (aexc_cur | flags);
    end
endmodule

// File: rtl/fpx_state_reg.sv
module fpx_state_reg
    import fpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  fpx_state_t wr_val,
    input  logic       op_valid,
    input  exc_vec_t   op_flags,
    input  exc_vec_t   aexc_next,
    input  logic       trap_hit,
    input  logic       cmp_valid,
    input  fcc_e       cmp_code,
    output fpx_state_t state,
    output logic       trap_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= '0;
            trap_pulse <= 1'b0;
        end else begin
            trap_pulse <= 1'b0;
            if (wr_en) begin
                state <= wr_val;
            end else begin
                if (op_valid) begin
                    state.cexc <= op_flags;
                    state.aexc <= aexc_next;
                    if (trap_hit) begin
                        trap_pulse <= 1'b1;
                        state.tt   <= TT_IEEE;
                    end
                end
                if (cmp_valid) begin
                    state.fcc <= cmp_code;
                end
            end
        end
    end
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wr_en,
    input  logic [CSR_W-1:0]  csr_wr_data,
    output logic [CSR_W-1:0]  csr_rd_data,
    input  logic              op_valid,
    input  logic [EXC_N-1:0]  op_flags,
    input  logic              cmp_valid,
    input  logic [1:0]        cmp_cc,
    input  logic              queue_busy,
    output logic [1:0]        round_mode,
    output logic              trap_req
);
    fpx_state_t st;
    fpx_state_t wr_val;
    exc_vec_t   aexc_next;
    logic       trap_hit;

    assign wr_val = fpx_unpack(csr_wr_data);

    fpx_exc_eval #(.N(EXC_N)) u_eval (
        .flags     (op_flags),
        .mask      (st.tem),
        .aexc_cur  (st.aexc),
        .trap_hit  (trap_hit),
        .aexc_next (aexc_next)
    );

    fpx_state_reg u_state (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (csr_wr_en),
        .wr_val     (wr_val),
        .op_valid   (op_valid),
        .op_flags   (op_flags),
        .aexc_next  (aexc_next),
        .trap_hit   (trap_hit),
        .cmp_valid  (cmp_valid),
        .cmp_code   (fcc_e'(cmp_cc)),
        .state      (st),
        .trap_pulse (trap_req)
    );

    assign csr_rd_data = fpx_pack(st, queue_busy);
    assign round_mode  = st.rm;
endmodule

// File: rtl/fpx_status_chk.sv
module fpx_status_chk
    import fpx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              csr_wr_en,
    input logic [CSR_W-1:0]  csr_wr_data,
    input logic [CSR_W-1:0]  csr_rd_data,
    input logic              op_valid,
    input logic [EXC_N-1:0]  op_flags,
    input logic              cmp_valid,
    input logic [1:0]        cmp_cc,
    input logic              queue_busy,
    input logic [1:0]        round_mode,
    input logic              trap_req
);
    logic [EXC_N-1:0] tem_f, cexc_f, aexc_f;
    logic [1:0]       fcc_f;
    logic [TT_W-1:0]  tt_f;
    logic             live_op, hit;

    assign tem_f   = csr_rd_data[TEM_LSB +: EXC_N];
    assign cexc_f  = csr_rd_data[CEXC_LSB +: EXC_N];
    assign aexc_f  = csr_rd_data[AEXC_LSB +: EXC_N];
    assign fcc_f   = csr_rd_data[FCC_LSB +: 2];
    assign tt_f    = csr_rd_data[TT_LSB +: TT_W];
    assign live_op = op_valid && !csr_wr_en;
    assign hit     = (op_flags & tem_f) != '0;

    a_r3_cexc_latest: assert property (@(posedge clk) disable iff (rst)
        live_op |=> cexc_f == $past(op_flags));

    a_r4_accrue_masked: assert property (@(posedge clk) disable iff (rst)
        (live_op && !hit) |=> aexc_f == ($past(aexc_f) | $past(op_flags)));

    a_r5_trap_raise: assert property (@(posedge clk) disable iff (rst)
        (live_op && hit) |=> (trap_req && tt_f == TT_IEEE && aexc_f == $past(aexc_f)));

    a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(live_op && hit) |=> !trap_req);

    a_r7_cmp_capture: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !csr_wr_en) |=> fcc_f == $past(cmp_cc));

    a_r2_write_back: assert property (@(posedge clk) disable iff (rst)
        csr_wr_en |=> csr_rd_data[STATE_W-1:0] == $past(csr_wr_data[STATE_W-1:0]));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !csr_wr_en) |=> ($stable(cexc_f) && $stable(aexc_f)));

    always_comb begin
        if (!rst) begin
            a_r2_pad_zero: assert (csr_rd_data[CSR_W-1:QNE_BIT+1] == '0);
        end
    end
endmodule

bind fpx_status_unit fpx_status_chk u_chk (.*);

// File: tb/tb_fpx_status_unit.sv
module tb_fpx_status_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        csr_wr_en;
    logic [31:0] csr_wr_data;
    logic [31:0] csr_rd_data;
    logic        op_valid;
    logic [4:0]  op_flags;
    logic        cmp_valid;
    logic [1:0]  cmp_cc;
    logic        queue_busy;
    logic [1:0]  round_mode;
    logic        trap_req;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic [1:0] m_rm, m_fcc;
    logic [4:0] m_tem, m_cexc, m_aexc;
    logic [2:0] m_tt;
    logic       m_trap;

    // 50 MHz: 20-unit period, units taken as ns
    always #10 clk = ~clk;

    fpx_status_unit dut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word(logic [4:0] tem, logic [4:0] cx, logic [4:0] ax,
                                        logic [1:0] cc, logic [2:0] tt, logic [1:0] rm);
        return {10'd0, tt, cc, ax, cx, tem, rm};
    endfunction

    task automatic cyc(logic wr, logic [31:0] wd, logic ov, logic [4:0] fl,
                       logic cv, logic [1:0] cc, logic qb);
        string t_cx, t_ax, t_cc, t_tt;
        csr_wr_en = wr; csr_wr_data = wd; op_valid = ov; op_flags = fl;
        cmp_valid = cv; cmp_cc = cc; queue_busy = qb;
        m_trap = 1'b0;
        if (wr) begin
            {m_tt, m_fcc, m_aexc, m_cexc, m_tem, m_rm} = wd[21:0];
            t_cx = (ov || cv) ? "R10" : "R2";
            t_ax = t_cx; t_cc = t_cx; t_tt = t_cx;
        end else begin
            t_cx = ov ? "R3" : "R11";
            t_ax = ov ? (((fl & m_tem) != 0) ? "R5" : "R4") : "R11";
            t_cc = "R7"; t_tt = "R5";
            if (ov) begin
                m_cexc = fl;
                if ((fl & m_tem) != 0) begin
                    m_trap = 1'b1; m_tt = 3'd1;
                end else begin
                    m_aexc = m_aexc | fl;
                end
            end
            if (cv) m_fcc = cc;
        end
        @(posedge clk); #2;
        chk(t_cx, 32'(csr_rd_data[11:7]),  32'(m_cexc), "current exceptions");
        chk(t_ax, 32'(csr_rd_data[16:12]), 32'(m_aexc), "accrued exceptions");
        chk(t_cc, 32'(csr_rd_data[18:17]), 32'(m_fcc),  "condition code");
        chk(t_tt, 32'(csr_rd_data[21:19]), 32'(m_tt),   "trap type");
        chk(wr ? ((ov || cv) ? "R10" : "R2") : "R2",
            32'(csr_rd_data[6:2]), 32'(m_tem), "trap mask");
        chk((wr && ov) ? "R10" : "R6", 32'(trap_req), 32'(m_trap), "trap_req");
        chk("R8", 32'(round_mode), 32'(m_rm), "round_mode");
        chk("R9", 32'(csr_rd_data[22]), 32'(qb), "queue flag");
        chk("R2", 32'(csr_rd_data[31:23]), 32'd0, "pad bits");
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; csr_wr_en = 0; csr_wr_data = '0; op_valid = 0; op_flags = '0;
        cmp_valid = 0; cmp_cc = '0; queue_busy = 0;
        m_rm = 0; m_fcc = 0; m_tem = 0; m_cexc = 0; m_aexc = 0; m_tt = 0; m_trap = 0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset state
        chk("R1", csr_rd_data, 32'd0, "word after reset");
        chk("R1", 32'(trap_req), 32'd0, "trap_req after reset");
        chk("R1", 32'(round_mode), 32'd0, "round_mode after reset");

        // R8: rounding toward +inf, all masks off
        cyc(1, word(5'd0, 5'd0, 5'd0, 2'd0, 3'd0, 2'd2), 0, 0, 0, 0, 0);
        // R4: invalid+inexact masked, accumulate
        cyc(0, 0, 1, 5'b10001, 0, 0, 0);
        // R3: division by zero alone clears the others
        cyc(0, 0, 1, 5'b00010, 0, 0, 1);
        // R11: idle
        cyc(0, 0, 0, 5'b11111, 0, 0, 1);
        // enable overflow trap, keep accrued
        cyc(1, word(5'b01000, 5'd0, 5'b10011, 2'd0, 3'd0, 2'd3), 0, 0, 0, 0, 0);
        // R5: overflow+inexact traps, accrued unchanged
        cyc(0, 0, 1, 5'b01001, 0, 0, 0);
        // R6: trap_req drops, tt holds
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R4 with mask set but flag not enabled
        cyc(0, 0, 1, 5'b00100, 0, 0, 0);
        // R7: every compare code, exception fields untouched
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 1, 2'(k), 0);
        // R10: write collides with enabled op and compare
        cyc(1, word(5'b11111, 5'd0, 5'd0, 2'd1, 3'd0, 2'd1), 1, 5'b11111, 1, 2'd3, 1);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R9: bit 22 write has no effect
        cyc(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        m_tt = 3'd7;

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic        w;
            logic [31:0] d;
            logic [4:0]  f;
            w = ($urandom % 12) == 0;
            d = $urandom;
            f = ($urandom % 3 == 0) ? 5'($urandom) : 5'(1 << ($urandom % 5));
            cyc(w, d, ($urandom % 4) != 0, f, ($urandom % 3) == 0,
                2'($urandom), 1'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule